// File: doc/BRIEF.md
# Bit-Bang Two-Wire Port Register

This peripheral gives software direct, bit-level control of a two-wire serial bus made of a clock line and a data line. It sits on a simple synchronous register bus with address, write strobe, write data, read strobe and read data. Software forms the bus protocol itself by raising and lowering the lines one register write at a time. There is no hardware protocol engine.

Lines are raised through a write-one-to-set register at offset 0x0 and lowered through a write-one-to-clear register at offset 0x4. Each line is open-drain. A latch value of zero turns on the pull-down, and a latch value of one releases the line to the external pull-up. The data line level passes through a synchroniser. It is captured into a readback bit on every bus write, at any offset. A read at offset 0x0 returns the latched clock state together with that captured data bit. A read at any other offset in the 4 KiB window returns all ones.

Top module: `twp_port`

## Requirements
- R1: After reset both pull-down enables are 0, so both lines are released. The captured data bit is 0, so a read at offset 0x0 returns 0x00000001.
- R2: A write to offset 0x0 sets each latch bit whose write-data bit is one: bit 0 is the clock and bit 1 is the data. Bits written as zero are unchanged, and write-data bits 31..2 are ignored.
- R3: A write to offset 0x4 clears each latch bit whose write-data bit is one, and leaves bits written as zero unchanged.
- R4: A read at offset 0x0 returns the clock latch in bit 0 and the captured data bit in bit 1, with bits 31..2 zero. Read data is valid on the cycle after the read strobe and holds until the next read.
- R5: A read at any offset other than 0x0 returns 0xFFFFFFFF.
- R6: A write to any offset other than 0x0 or 0x4 leaves both latches unchanged.
- R7: Each line's pull-down enable is the inverse of its latch: latch 0 drives low, and latch 1 releases.
- R8: The data input passes through a two-flop synchroniser. It is captured into the readback bit only at the clock edge of a bus write, including a write to an unmapped offset. Without a write, the read value keeps its old data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| clk_line_pd | output | 1 | Clock line pull-down enable |
| dat_line_pd | output | 1 | Data line pull-down enable |
| dat_line_in | input | 1 | Data line level as seen at the pad |

## Verification
Several properties are checked on every cycle:
- a set write leaves every written-one bit high, and a clear write leaves every written-one bit low;
- unmapped writes leave the latches untouched;
- unmapped reads return all ones;
- a read at 0x0 has zero upper bits and reports the prior clock latch;
- the captured data bit never moves without a write.

Only the bench scenarios can show the end-to-end behaviour. These cover the reset value, and the open-drain behaviour against an external device holding the data line low. They also show that a change on the line stays invisible until a write re-samples it, and that the pad level captured is the one from before the write's own edge.

// File: rtl/twp_pkg.sv
package twp_pkg;
    localparam int DATA_W  = 32;
    localparam int LINES   = 2;
    localparam int CLK_BIT = 0;
    localparam int DAT_BIT = 1;

    typedef struct packed {
        logic [LINES-1:0]  lat;
        logic              cap;
        logic [DATA_W-1:0] rdata;
    } twp_state_t;
endpackage

// File: rtl/twp_sync.sv
module twp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] s_d, s_q;

    assign s_d[0] = d;
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        assign s_d[i] = s_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign q = s_q[STAGES-1];
endmodule

// File: rtl/twp_regs.sv
module twp_regs
    import twp_pkg::*;
#(
    parameter int               ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] SET_OFS = 'h0,
    parameter logic [ADDR_W-1:0] CLR_OFS = 'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              sda_sync,
    output logic [DATA_W-1:0] rdata,
    output logic [LINES-1:0]  lat
);
    twp_state_t st_d, st_q;
    logic hit_set, hit_clr;

    assign hit_set = (addr == SET_OFS);
    assign hit_clr = (addr == CLR_OFS);

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.cap = sda_sync;
            if (hit_set)      st_d.lat = st_q.lat | wdata[LINES-1:0];
            else if (hit_clr) st_d.lat = st_q.lat & ~wdata[LINES-1:0];
        end
        if (rd) begin
            if (hit_set) begin
                st_d.rdata          = '0;
                st_d.rdata[CLK_BIT] = st_q.lat[CLK_BIT];
                st_d.rdata[DAT_BIT] = st_q.cap;
            end else begin
                st_d.rdata = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lat   <= '1;
            st_q.cap   <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;
    assign lat   = st_q.lat;

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_set) |=> ((lat & $past(wdata[LINES-1:0])) == $past(wdata[LINES-1:0])));

    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_clr) |=> ((lat & $past(wdata[LINES-1:0])) == '0));

    p_rd_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && hit_set) |=> (rdata[DATA_W-1:LINES] == '0 && rdata[CLK_BIT] == $past(lat[CLK_BIT])));

    p_unmapped_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit_set) |=> (rdata == '1));

    p_unmapped_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !hit_set && !hit_clr) |=> $stable(lat));

    p_cap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(st_q.cap));
endmodule

// File: rtl/twp_port.sv
module twp_port
    import twp_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              clk_line_pd,
    output logic              dat_line_pd,
    input  logic              dat_line_in
);
    logic             dat_sync;
    logic [LINES-1:0] lat;

    twp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dat_line_in),
        .q     (dat_sync)
    );

    twp_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .rd       (bus_rd),
        .sda_sync (dat_sync),
        .rdata    (bus_rdata),
        .lat      (lat)
    );

    assign clk_line_pd = ~lat[CLK_BIT];
    assign dat_line_pd = ~lat[DAT_BIT];

    p_wr_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == '0 && bus_wdata[CLK_BIT]) |=> !clk_line_pd);
endmodule

// File: tb/tb_twp_port.sv
`timescale 1ns/1ps
module tb_twp_port;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 0;
    logic [31:0] bus_rdata;
    logic        clk_line_pd, dat_line_pd;
    logic        ext_low = 0;
    logic        dat_line_in;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [1:0] exp_lat;
    logic       exp_cap;

    always #2.5 clk = ~clk;

    assign dat_line_in = !dat_line_pd && !ext_low;

    twp_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .clk_line_pd(clk_line_pd), .dat_line_pd(dat_line_pd), .dat_line_in(dat_line_in)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        idle(3);
        exp_cap = exp_lat[1] && !ext_low;
        if (a == 12'h0)      exp_lat = exp_lat | d[1:0];
        else if (a == 12'h4) exp_lat = exp_lat & ~d[1:0];
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        v = bus_rdata;
    endtask

    task automatic check_lines(input string req);
        check(req, {30'b0, dat_line_pd, clk_line_pd}, {30'b0, ~exp_lat[1], ~exp_lat[0]});
    endtask

    function automatic logic [31:0] exp_rd0();
        return {30'b0, exp_cap, exp_lat[0]};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        check("R1 lines released", {30'b0, dat_line_pd, clk_line_pd}, 32'h0);
        rd(12'h0, v);
        check("R1 reset readback", v, 32'h1);
    endtask

    task automatic t_set_clr_each();
        logic [31:0] v;
        wr(12'h4, 32'h1);
        check_lines("R3 clear clock only");
        check("R7 clock pulled down", {31'b0, clk_line_pd}, 32'h1);
        rd(12'h0, v); check("R4 readback clock low", v, exp_rd0());
        wr(12'h0, 32'h1);
        check_lines("R2 set clock only");
        wr(12'h4, 32'h2);
        check_lines("R3 clear data only");
        check("R7 data pulled down", {31'b0, dat_line_pd}, 32'h1);
        wr(12'h0, 32'hFFFF_FFFC);
        check_lines("R2 upper bits ignored");
        wr(12'h0, 32'h2);
        check_lines("R2 set data only");
        rd(12'h0, v); check("R8 data captured before own edge", v, exp_rd0());
    endtask

    task automatic t_set_both();
        logic [31:0] v;
        wr(12'h4, 32'h3);
        check_lines("R3 clear both");
        wr(12'h0, 32'h3);
        check_lines("R2 set both");
        wr(12'h0, 32'h0);
        check_lines("R2 zero write no change");
        rd(12'h0, v); check("R4 readback both high", v, exp_rd0());
    endtask

    task automatic t_hold_low();
        logic [31:0] v;
        ext_low = 1;
        wr(12'h0, 32'h2);
        rd(12'h0, v); check("R4 external hold low", v, exp_rd0());
        check("R7 data released while held", {31'b0, dat_line_pd}, 32'h0);
        ext_low = 0;
        rd(12'h0, v); check("R8 no resample without write", v, 32'h1);
        wr(12'h10, 32'h3);
        rd(12'h0, v); check("R8 unmapped write resamples", v, 32'h3);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(12'h4, v);   check("R5 read at 0x4", v, 32'hFFFF_FFFF);
        rd(12'hFFC, v); check("R5 read at 0xFFC", v, 32'hFFFF_FFFF);
        rd(12'h1, v);   check("R5 read at 0x1", v, 32'hFFFF_FFFF);
        idle(2);
        check("R4 read data holds", bus_rdata, 32'hFFFF_FFFF);
        wr(12'h8, 32'h3);
        check_lines("R6 unmapped write 0x8");
        wr(12'h4, 32'h1);
        wr(12'h800, 32'h3);
        check_lines("R6 unmapped write 0x800");
        rd(12'h0, v); check("R6 readback after unmapped", v, exp_rd0());
    endtask

    initial begin
        exp_lat = 2'b11; exp_cap = 0;
        idle(4);
        rst_n = 1;
        idle(1);
        t_reset();
        t_set_clr_each();
        t_set_both();
        t_hold_low();
        t_unmapped();
        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule